// File: doc/BRIEF.md
# Upper Memory Window Router with Wait-State Insertion

This block sits between a CPU bus and three memory targets that share a single upper physical address window: shared memory, flash and traffic memory. A CPU memory access whose address falls inside the window is routed to exactly one target, through that target's chip select. The choice comes from an 8-bit control register that the CPU writes and reads over its I/O space. Memory accesses outside the window leave every chip select inactive.

The same register can also lengthen window accesses. It has two independent wait-state fields whose counts add, and the block holds its wait output asserted for that number of cycles from the first cycle of an access.

A further register bit drives an output that tells the backplane logic to swap the address-modifier codes used for shared memory and traffic memory. The block captures the target and the wait count when an access starts. A register write made during an access therefore changes nothing until the next access begins.

Top module: `memwin_router`

## Requirements
- R1: The window spans addresses 0xC0000 to 0xFFFFF inclusive. A memory access to any address outside that span asserts no chip select and no wait.
- R2: The register is written and read at I/O address 0x80, decoded from `addr_i[7:0]`. A read there returns the stored byte. A read at any other I/O address returns 0. Writes to any other I/O address, including the CPU-internal range 0x00 to 0x3F, leave the register unchanged.
- R3: After reset the register holds 0x00. Window accesses then go to shared memory with no wait states, and `am_swap_o` is 0.
- R4: Bit 3 = 1 selects traffic memory regardless of bit 2. With bit 3 = 0, bit 2 = 1 selects flash and bit 2 = 0 selects shared memory. At most one chip select is ever active.
- R5: The wait count is 2 when bit 5 is set, plus 3 when bit 6 is set, giving 0, 2, 3 or 5. During a window access, `wait_o` is high for exactly that many cycles, starting in the access's first cycle.
- R6: `am_swap_o` equals register bit 7.
- R7: An access keeps the target and wait count that were in force in its first cycle. A register write during the access takes effect from the next access.
- R8: Register bits 0, 1 and 4 are stored and read back unchanged and have no effect on routing or wait count.
- R9: An access is the span of cycles with `mem_req_i` high. Each rising edge of `mem_req_i` starts a new access and reloads the wait count. With `mem_req_i` low, every chip select and `wait_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 20 | Physical address; the low 8 bits form the I/O address |
| io_req_i | input | 1 | I/O access strobe |
| mem_req_i | input | 1 | Memory access strobe, held for the whole access |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Write data for I/O writes |
| rdata_o | output | 8 | Register read data (0 when the register is not addressed) |
| wait_o | output | 1 | Stretches the current access while high |
| cs_shm_o | output | 1 | Shared-memory chip select |
| cs_flash_o | output | 1 | Flash chip select |
| cs_traffic_o | output | 1 | Traffic-memory chip select |
| am_swap_o | output | 1 | Swap address-modifier codes of shared and traffic memory |

## Verification
The register can hold a wrong value, for example after a write at a stray I/O address or a mis-decoded bit. That error shows on the very next read at 0x80. It also shows on the next window access, as a wrong chip select or as a wait pulse that is too long or too short.

The wait counter or the latched target can be stale or reloaded wrongly. That appears within the same access, as a chip select that changes mid-access or a wait pulse whose length differs from the count the register defined at the access's first cycle. Sweeping all 256 register values with one access each, plus the restart and mid-access write cases, exposes these errors within a few cycles of their cause.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  typedef enum logic [1:0] {
    TGT_SHM     = 2'd0,
    TGT_FLASH   = 2'd1,
    TGT_TRAFFIC = 2'd2
  } tgt_e;

  localparam int NUM_TGT     = 3;
  localparam int BIT_FLASH   = 2;
  localparam int BIT_TRAFFIC = 3;
  localparam int BIT_WS_A    = 5;
  localparam int BIT_WS_B    = 6;
  localparam int BIT_SWAP    = 7;

  // Traffic memory wins over the flash/shared choice.
  function automatic tgt_e pick_target(input logic [7:0] cfg);
    if (cfg[BIT_TRAFFIC])    return TGT_TRAFFIC;
    else if (cfg[BIT_FLASH]) return TGT_FLASH;
    else                     return TGT_SHM;
  endfunction

  // The two wait-state fields add.
  function automatic int unsigned wait_states(input logic [7:0] cfg,
                                              input int unsigned ws_a,
                                              input int unsigned ws_b);
    int unsigned n;
    n = 0;
    if (cfg[BIT_WS_A]) n = n + ws_a;
    if (cfg[BIT_WS_B]) n = n + ws_b;
    return n;
  endfunction

endpackage

// File: rtl/memwin_cfg_reg.sv
module memwin_cfg_reg #(
  parameter int               IO_AW   = 8,
  parameter logic [IO_AW-1:0] IO_ADDR = 8'h80,
  parameter logic [7:0]       RST_VAL = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       cfg_o,
  output logic [7:0]       rdata_o,
  output logic             wr_hit_o
);

  logic addr_hit;
  logic rd_hit;

  assign addr_hit = (io_addr == IO_ADDR);
  assign wr_hit_o = io_req && wr && addr_hit;
  assign rd_hit   = io_req && !wr && addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_o <= RST_VAL;
    else if (wr_hit_o) cfg_o <= wdata;
  end

  assign rdata_o = rd_hit ? cfg_o : 8'h00;

endmodule

// File: rtl/memwin_decode.sv
module memwin_decode #(
  parameter int            AW   = 20,
  parameter logic [AW-1:0] BASE = 20'hC0000,
  parameter logic [AW-1:0] LAST = 20'hFFFFF
) (
  input  logic [AW-1:0] addr,
  output logic          hit_o
);

  assign hit_o = (addr >= BASE) && (addr <= LAST);

endmodule

// File: rtl/memwin_wait.sv
module memwin_wait #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             wait_o
);

  logic [CNT_W-1:0] cnt;

  // The first cycle is covered by start, so the counter holds load-1.
  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!active)     cnt <= '0;
    else if (start)       cnt <= (load == '0) ? '0 : load - 1'b1;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign wait_o = active && (start ? (load != '0) : (cnt != '0));

endmodule

// File: rtl/memwin_router.sv
module memwin_router #(
  parameter int               AW       = 20,
  parameter int               IO_AW    = 8,
  parameter logic [IO_AW-1:0] IO_ADDR  = 8'h80,
  parameter logic [AW-1:0]    WIN_BASE = 20'hC0000,
  parameter logic [AW-1:0]    WIN_LAST = 20'hFFFFF,
  parameter int               WS_A     = 2,
  parameter int               WS_B     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          io_req_i,
  input  logic          mem_req_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          wait_o,
  output logic          cs_shm_o,
  output logic          cs_flash_o,
  output logic          cs_traffic_o,
  output logic          am_swap_o
);

  import memwin_pkg::*;

  localparam int CNT_W = $clog2(WS_A + WS_B + 1);

  logic [7:0]         cfg;
  logic               cfg_wr_hit;
  logic               hit_live;
  logic [1:0]         tgt_live;
  logic [CNT_W-1:0]   wait_n;
  logic [CNT_W-1:0]   wait_load;
  logic               mem_q;
  logic               acc_start;
  logic               hit_q;
  logic [1:0]         tgt_q;
  logic               eff_hit;
  logic [1:0]         eff_tgt;
  logic [NUM_TGT-1:0] cs_vec;

  memwin_cfg_reg #(.IO_AW(IO_AW), .IO_ADDR(IO_ADDR), .RST_VAL(8'h00)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_req  (io_req_i),
    .wr      (wr_i),
    .io_addr (addr_i[IO_AW-1:0]),
    .wdata   (wdata_i),
    .cfg_o   (cfg),
    .rdata_o (rdata_o),
    .wr_hit_o(cfg_wr_hit)
  );

  memwin_decode #(.AW(AW), .BASE(WIN_BASE), .LAST(WIN_LAST)) u_dec (
    .addr (addr_i),
    .hit_o(hit_live)
  );

  assign tgt_live  = pick_target(cfg);
  assign wait_n    = CNT_W'(wait_states(cfg, WS_A, WS_B));
  assign wait_load = hit_live ? wait_n : '0;

  // A new access begins on a rising memory strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) mem_q <= 1'b0;
    else        mem_q <= mem_req_i;
  end
  assign acc_start = mem_req_i && !mem_q;

  // Target and window hit are frozen for the rest of the access.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      tgt_q <= TGT_SHM;
    end else if (acc_start) begin
      hit_q <= hit_live;
      tgt_q <= tgt_live;
    end
  end

  assign eff_hit = acc_start ? hit_live : hit_q;
  assign eff_tgt = acc_start ? tgt_live : tgt_q;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_cs
    assign cs_vec[i] = mem_req_i && eff_hit && (eff_tgt == 2'(i));
  end

  assign cs_shm_o     = cs_vec[TGT_SHM];
  assign cs_flash_o   = cs_vec[TGT_FLASH];
  assign cs_traffic_o = cs_vec[TGT_TRAFFIC];

  memwin_wait #(.CNT_W(CNT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .active(mem_req_i),
    .start (acc_start),
    .load  (wait_load),
    .wait_o(wait_o)
  );

  assign am_swap_o = cfg[BIT_SWAP];

endmodule

// File: rtl/memwin_router_chk.sv
module memwin_router_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             io_req,
  input logic             wr,
  input logic [7:0]       io_addr,
  input logic [7:0]       cfg,
  input logic             start,
  input logic             hit_live,
  input logic [CNT_W-1:0] load,
  input logic [2:0]       cs_vec,
  input logic             wait_o
);

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_vec));

  p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hit_live) |-> (cs_vec == 3'b000 && !wait_o));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (cs_vec == 3'b000 && !wait_o));

  p_low_io_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && wr && io_addr < 8'h40) |=> $stable(cfg));

  p_wait_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && load != '0) |-> wait_o);

  p_hold_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !start) |-> $stable(cs_vec));

endmodule

bind memwin_router memwin_router_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_req (mem_req_i),
  .io_req  (io_req_i),
  .wr      (wr_i),
  .io_addr (addr_i[7:0]),
  .cfg     (cfg),
  .start   (acc_start),
  .hit_live(hit_live),
  .load    (wait_load),
  .cs_vec  (cs_vec),
  .wait_o  (wait_o)
);

// File: tb/memwin_router_tb_top.sv
`timescale 1ns/1ps
module memwin_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr_i = '0;
  logic        io_req_i = 1'b0;
  logic        mem_req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        wait_o, cs_shm_o, cs_flash_o, cs_traffic_o, am_swap_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  memwin_router dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .io_req_i(io_req_i),
    .mem_req_i(mem_req_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .wait_o(wait_o), .cs_shm_o(cs_shm_o), .cs_flash_o(cs_flash_o),
    .cs_traffic_o(cs_traffic_o), .am_swap_o(am_swap_o)
  );

  function automatic logic [2:0] exp_cs(input logic [7:0] c, input logic hit);
    if (!hit)      return 3'b000;
    if (c[3])      return 3'b100;
    if (c[2])      return 3'b010;
    return 3'b001;
  endfunction

  function automatic int exp_wait(input logic [7:0] c);
    return 2 * int'(c[5]) + 3 * int'(c[6]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_req_i = 1'b1; wr_i = 1'b1; addr_i = {12'h000, a}; wdata_i = d;
    @(negedge clk);
    io_req_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_req_i = 1'b1; wr_i = 1'b0; addr_i = {12'h000, a};
    #1 d = rdata_o;
    @(negedge clk);
    io_req_i = 1'b0;
  endtask

  // One memory access; counts wait cycles and checks chip selects each cycle.
  task automatic mem_access(input logic [19:0] a, input logic [2:0] cs_exp,
                            input int n_exp, input string req);
    int k;
    @(negedge clk);
    mem_req_i = 1'b1; addr_i = a;
    #1;
    k = 0;
    check({cs_traffic_o, cs_flash_o, cs_shm_o} == cs_exp, req,
          {cs_traffic_o, cs_flash_o, cs_shm_o}, cs_exp);
    while (wait_o && k < 20) begin
      k++;
      @(negedge clk); #1;
      check({cs_traffic_o, cs_flash_o, cs_shm_o} == cs_exp, {req, " hold R7"},
            {cs_traffic_o, cs_flash_o, cs_shm_o}, cs_exp);
    end
    check(k == n_exp, {req, " wait R5"}, k, n_exp);
    @(negedge clk);
    mem_req_i = 1'b0;
    #1 check({wait_o, cs_traffic_o, cs_flash_o, cs_shm_o} == 4'b0, "R9 idle",
             {wait_o, cs_traffic_o, cs_flash_o, cs_shm_o}, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    io_read(8'h80, rd);
    check(rd == 8'h00, "R3 reset value", rd, 0);
    check(am_swap_o == 1'b0, "R3 swap", am_swap_o, 0);
    mem_access(20'hC1234, 3'b001, 0, "R3 reset target");

    // R1 window boundaries
    mem_access(20'hC0000, 3'b001, 0, "R1 low edge");
    mem_access(20'hFFFFF, 3'b001, 0, "R1 high edge");
    io_write(8'h80, 8'h6C);
    mem_access(20'hBFFFF, 3'b000, 0, "R1 below window");
    mem_access(20'h00000, 3'b000, 0, "R1 zero addr");

    // R2 stray I/O writes, including the CPU-internal range
    io_write(8'h80, 8'h00);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h80) io_write(8'(a), 8'hFF);
    end
    io_read(8'h80, rd);
    check(rd == 8'h00, "R2 stray writes ignored", rd, 0);
    io_write(8'h80, 8'h5A);
    io_read(8'h81, rd);
    check(rd == 8'h00, "R2 other address reads 0", rd, 0);
    io_read(8'h3F, rd);
    check(rd == 8'h00, "R2 internal range reads 0", rd, 0);

    // Full sweep of register values: R2, R4, R5, R6, R8
    for (int c = 0; c < 256; c++) begin
      io_write(8'h80, 8'(c));
      io_read(8'h80, rd);
      check(rd == 8'(c), "R2/R8 readback", rd, c);
      check(am_swap_o == rd[7], "R6 swap bit", am_swap_o, rd[7]);
      mem_access({2'b11, 18'(c * 1031)}, exp_cs(8'(c), 1'b1), exp_wait(8'(c)),
                 "R4 target");
      if ((c % 16) == 0)
        mem_access(20'h80000 + 20'(c), 3'b000, 0, "R1 outside");
    end

    // R8 bits 0,1,4 alone: shared memory, no waits
    io_write(8'h80, 8'h13);
    mem_access(20'hE0000, 3'b001, 0, "R8 inert bits");

    // R7 write during an access
    io_write(8'h80, 8'h60);
    @(negedge clk);
    mem_req_i = 1'b1; addr_i = 20'hD0000;
    #1 check(wait_o && cs_shm_o, "R7 start", {wait_o, cs_shm_o}, 3);
    @(negedge clk);
    io_req_i = 1'b1; wr_i = 1'b1; addr_i = 20'h00080; wdata_i = 8'h0C;
    #1 check(cs_shm_o && !cs_traffic_o, "R7 before write", cs_shm_o, 1);
    k = 2;
    @(negedge clk);
    io_req_i = 1'b0; wr_i = 1'b0;
    #1;
    while (wait_o && k < 20) begin
      check(cs_shm_o && !cs_traffic_o, "R7 keeps target", cs_shm_o, 1);
      k++;
      @(negedge clk); #1;
    end
    check(k == 5, "R7 keeps wait count", k, 5);
    @(negedge clk);
    mem_req_i = 1'b0;
    mem_access(20'hD0000, 3'b100, 0, "R7 next access");

    // R9 restart reloads the count
    io_write(8'h80, 8'h60);
    @(negedge clk);
    mem_req_i = 1'b1; addr_i = 20'hF0000;
    @(negedge clk);
    @(negedge clk);
    mem_req_i = 1'b0;
    #1 check(!wait_o, "R9 drop ends wait", wait_o, 0);
    mem_access(20'hF0000, 3'b001, 5, "R9 reload");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule